// File: doc/BRIEF.md
# Even-Ratio Clock Divider with Deferred Ratio Update

This block sits after a PLL and derives the system clock from it by dividing the PLL clock by an even ratio. Software supplies a setting field; the ratio is the setting plus one, so only odd settings are legal. The divided clock is produced from a register and has an exact 50% duty cycle.

A written setting is first held in a pending register. It becomes the active ratio only when the divided clock next falls. The current high phase therefore always finishes at its old length, and no short pulse appears. A write is refused, and an error flag raised, when the PLL is not locked or when the setting is even. While the PLL is switched off, the output carries the bypass clock input and the divider is not used.

Top module: `pll_even_divider`

## Requirements
- R1: The divided output period equals (active setting + 1) PLL clock cycles.
- R2: The divided output is high for exactly (setting + 1)/2 PLL cycles and then low for exactly (setting + 1)/2 PLL cycles.
- R3: While reset is held and just after it, the output is low, the error flag is low, and the active setting is 1, which gives a ratio of 2.
- R4: An accepted setting takes effect at the next falling edge of the divided clock. The high phase in progress completes at the old length, and the following low phase uses the new length.
- R5: A write whose setting has bit 0 equal to 0 (an even setting) is rejected. The active and pending ratios stay unchanged, and the error flag goes high one cycle after the write.
- R6: A write made while the lock input is low is ignored, and the error flag goes high one cycle after the write.
- R7: A write that is accepted (locked, and bit 0 of the setting equal to 1) clears the error flag one cycle after the write.
- R8: A second legal write made before the pending setting has been applied replaces it. Only the later value takes effect.
- R9: While the PLL-off input is high, the output equals the bypass clock input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll_i | input | 1 | PLL output clock, the clock being divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pll_off_i | input | 1 | PLL-off mode: the output follows the bypass clock |
| bypass_clk_i | input | 1 | Clock passed to the output in PLL-off mode |
| lock_i | input | 1 | PLL lock indication; writes are honoured only while it is high |
| wr_en_i | input | 1 | Write strobe for the setting, one PLL cycle wide |
| wr_set_i | input | SET_W | Divider setting; ratio = setting + 1 |
| clk_out_o | output | 1 | Divided clock, or the bypass clock in PLL-off mode |
| err_o | output | 1 | High after a rejected write, low after an accepted one |

## Verification
The hardest situation to create is a ratio change that lands in the middle of a long high phase. The stimulus switches to the largest ratio and waits for a rising output edge. It then writes a short ratio, and for the shadow test a second one, while the output is still high. It then counts the remaining high cycles, which must keep the old length, and the following low cycles, which must have the new length. All of these lengths are counted by sampling the output once per PLL cycle, between clock edges.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
    localparam int DEF_SET_W = 6;

    // odd setting <=> even ratio
    function automatic logic setting_legal(input logic lsb);
        return lsb;
    endfunction
endpackage

// File: rtl/pll_div_shadow.sv
module pll_div_shadow
    import pll_div_pkg::*;
#(
    parameter int SET_W = DEF_SET_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic             lock_i,
    input  logic [SET_W-1:0] wr_set_i,
    input  logic             take_i,
    output logic             pend_vld_o,
    output logic [SET_W-1:0] pend_set_o,
    output logic             err_o
);
    typedef struct packed {
        logic             vld;
        logic [SET_W-1:0] set;
        logic             err;
    } shd_t;

    shd_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (take_i) s_d.vld = 1'b0;
        if (wr_en_i) begin
            if (lock_i && setting_legal(wr_set_i[0])) begin
                s_d.vld = 1'b1;
                s_d.set = wr_set_i;
                s_d.err = 1'b0;
            end else begin
                s_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign pend_vld_o = s_q.vld;
    assign pend_set_o = s_q.set;
    assign err_o      = s_q.err;

    assert_unlocked_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !lock_i) |=> (err_o && pend_set_o == $past(pend_set_o)));

    assert_even_rejected_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_set_i[0]) |=> (err_o && pend_set_o == $past(pend_set_o)));

    assert_accept_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && lock_i && wr_set_i[0]) |=> (!err_o && pend_vld_o));
endmodule

// File: rtl/pll_div_core.sv
module pll_div_core
    import pll_div_pkg::*;
#(
    parameter int SET_W = DEF_SET_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pend_vld_i,
    input  logic [SET_W-1:0] pend_set_i,
    output logic             take_o,
    output logic             div_o
);
    localparam logic [SET_W-1:0] RST_SET = SET_W'(1);

    typedef struct packed {
        logic [SET_W-1:0] cnt;
        logic [SET_W-1:0] set;
        logic             div;
    } core_t;

    core_t c_d, c_q;
    logic  term;

    // half period minus one is setting >> 1
    assign term   = (c_q.cnt == {1'b0, c_q.set[SET_W-1:1]});
    assign take_o = term && c_q.div && pend_vld_i;

    always_comb begin
        c_d = c_q;
        if (term) begin
            c_d.cnt = '0;
            c_d.div = ~c_q.div;
            if (take_o) c_d.set = pend_set_i;
        end else begin
            c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '{cnt: '0, set: RST_SET, div: 1'b0};
        else         c_q <= c_d;
    end

    assign div_o = c_q.div;

    assert_active_odd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        c_q.set[0]);

    assert_change_at_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_q.set != $past(c_q.set)) |-> ($past(c_q.div) && !c_q.div));

    assert_cnt_in_half_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        c_q.cnt <= {1'b0, c_q.set[SET_W-1:1]});
endmodule

// File: rtl/pll_even_divider.sv
module pll_even_divider
    import pll_div_pkg::*;
#(
    parameter int SET_W = DEF_SET_W
) (
    input  logic             clk_pll_i,
    input  logic             rst_ni,
    input  logic             pll_off_i,
    input  logic             bypass_clk_i,
    input  logic             lock_i,
    input  logic             wr_en_i,
    input  logic [SET_W-1:0] wr_set_i,
    output logic             clk_out_o,
    output logic             err_o
);
    logic             pend_vld;
    logic [SET_W-1:0] pend_set;
    logic             take;
    logic             div_clk;

    pll_div_shadow #(.SET_W(SET_W)) u_shadow (
        .clk_i      (clk_pll_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .lock_i     (lock_i),
        .wr_set_i   (wr_set_i),
        .take_i     (take),
        .pend_vld_o (pend_vld),
        .pend_set_o (pend_set),
        .err_o      (err_o)
    );

    pll_div_core #(.SET_W(SET_W)) u_core (
        .clk_i      (clk_pll_i),
        .rst_ni     (rst_ni),
        .pend_vld_i (pend_vld),
        .pend_set_i (pend_set),
        .take_o     (take),
        .div_o      (div_clk)
    );

    assign clk_out_o = pll_off_i ? bypass_clk_i : div_clk;

    assert_bypass_R9: assert property (@(posedge clk_pll_i) disable iff (!rst_ni)
        pll_off_i |-> (clk_out_o == bypass_clk_i));
endmodule

// File: tb/pll_even_divider_tb.sv
module pll_even_divider_tb;
    localparam int SET_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pll_off = 1'b0;
    logic             byp = 1'b0;
    logic             lock = 1'b1;
    logic             wr_en = 1'b0;
    logic [SET_W-1:0] wr_set = '0;
    logic             clk_out;
    logic             err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pll_even_divider #(.SET_W(SET_W)) u_dut (
        .clk_pll_i    (clk),
        .rst_ni       (rst_n),
        .pll_off_i    (pll_off),
        .bypass_clk_i (byp),
        .lock_i       (lock),
        .wr_en_i      (wr_en),
        .wr_set_i     (wr_set),
        .clk_out_o    (clk_out),
        .err_o        (err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one write strobe, driven between edges
    task automatic write_set(input logic [SET_W-1:0] v);
        @(negedge clk);
        wr_en  = 1'b1;
        wr_set = v;
        @(negedge clk);
        wr_en  = 1'b0;
    endtask

    task automatic wait_rise();
        int guard = 0;
        while (clk_out !== 1'b0 && guard < 300) begin @(negedge clk); guard++; end
        while (clk_out !== 1'b1 && guard < 300) begin @(negedge clk); guard++; end
    endtask

    // count the length of the current level run, starting from the present sample
    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (clk_out === lvl && n < 300) begin n++; @(negedge clk); end
    endtask

    task automatic measure(output int hi, output int lo);
        wait_rise();
        run_len(1'b1, hi);
        run_len(1'b0, lo);
    endtask

    task automatic settle();
        int hi, lo;
        measure(hi, lo);
        measure(hi, lo);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R3 out in reset", clk_out, 0);
        check("R3 err in reset", err, 0);
        rst_n = 1'b1;
        begin
            int hi, lo;
            measure(hi, lo);
            check("R3 default high", hi, 1);
            check("R3 default low", lo, 1);
        end
    endtask

    task automatic t_ratio(input logic [SET_W-1:0] s);
        int hi, lo;
        write_set(s);
        check("R7 err after accepted write", err, 0);
        settle();
        measure(hi, lo);
        check("R1 period", hi + lo, int'(s) + 1);
        check("R2 high half", hi, (int'(s) + 1) / 2);
        check("R2 low half", lo, (int'(s) + 1) / 2);
    endtask

    task automatic t_even_reject();
        int hi, lo;
        write_set(6'd4);
        check("R5 err on even setting", err, 1);
        settle();
        measure(hi, lo);
        check("R5 ratio kept high", hi, 3);
        check("R5 ratio kept low", lo, 3);
    endtask

    task automatic t_unlocked();
        int hi, lo;
        lock = 1'b0;
        write_set(6'd9);
        lock = 1'b1;
        check("R6 err on unlocked write", err, 1);
        settle();
        measure(hi, lo);
        check("R6 ratio kept high", hi, 3);
        check("R6 ratio kept low", lo, 3);
        write_set(6'd5);
        check("R7 err cleared", err, 0);
    endtask

    task automatic t_deferral();
        int hi, lo, hi2;
        write_set(6'd63);
        settle();
        wait_rise();
        // first high sample seen; write ratio 2 mid-phase
        wr_en  = 1'b1;
        wr_set = 6'd1;
        @(negedge clk);
        wr_en  = 1'b0;
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        run_len(1'b1, hi2);
        check("R4 old high completes", hi + 1, 32);
        check("R4 new low length", lo, 1);
        check("R4 new high length", hi2, 1);
    endtask

    task automatic t_shadow();
        int hi, lo, hi2;
        write_set(6'd63);
        settle();
        wait_rise();
        wr_en  = 1'b1;
        wr_set = 6'd3;
        @(negedge clk);
        wr_set = 6'd9;
        @(negedge clk);
        wr_en  = 1'b0;
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        run_len(1'b1, hi2);
        check("R8 old high completes", hi + 2, 32);
        check("R8 later value low", lo, 5);
        check("R8 later value high", hi2, 5);
    endtask

    task automatic t_bypass();
        pll_off = 1'b1;
        for (int i = 0; i < 12; i++) begin
            byp = (i % 3) != 0;
            @(negedge clk);
            #1;
            check("R9 output follows bypass", clk_out, byp);
        end
        pll_off = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_ratio(6'd5);
        t_ratio(6'd63);
        t_ratio(6'd1);
        t_ratio(6'd5);
        t_even_reject();
        t_unlocked();
        t_deferral();
        t_shadow();
        t_bypass();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule